// File: doc/BRIEF.md
# Destination Connection Handshake Controller

This block sits on the receiving end of a point-to-point channel and runs the connection setup. A remote sender raises a request line and places a header word, the I-field, on the channel data bus. The request line is not synchronous to the local clock. The block brings it into the local clock domain through a flop synchronizer and captures the header word. It then shows the word to the host together with a pending-connection flag.

The host decides in its own time. If it accepts, the block drives the channel's connect line a fixed two cycles later. If it rejects, the connect line stays low until the sender withdraws its request. If the sender withdraws before a decision is made, the pending flag is cleared and connect is never driven. Withdrawal during an established connection drops connect promptly.

The time from request to host notification is four or five cycles. The time from accept to connect is two cycles. The total setup cost is therefore six or seven cycles plus whatever time the host takes to decide.

Top module: `dst_conn_ctrl`

## Requirements
- R1: While reset is applied and right after it, `chan_connect_o` and `host_pending_o` are 0 and `host_ifield_o` is all zeros.
- R2: A channel request that is set up before a rising edge raises `host_pending_o` on the fourth rising edge and not before. A request that arrives close to an edge may take one more edge, so five at most.
- R3: When `host_pending_o` rises, `host_ifield_o` equals the word that was on `chan_data_i` while the request was held. It then keeps that value, whatever the bus does, until the next request is captured.
- R4: If `host_accept_i` is high at a rising edge while the flag is up, the flag falls on that edge and `chan_connect_o` rises on the next edge. That is the second edge after accept was raised.
- R5: If the request is removed while the flag is up and no decision has been made, the flag falls on the third edge after removal. `chan_connect_o` stays 0, and a later accept has no effect.
- R6: If the request is removed while connected, `chan_connect_o` falls on the third rising edge after removal.
- R7: If `host_reject_i` is high at an edge while the flag is up, the flag falls. `chan_connect_o` then stays 0, even under accept, until the request is removed. After that, a new request is handled normally.
- R8: If reject and accept are both high at the same edge, reject wins.
- R9: Accept or reject given while no request is pending changes neither output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_req_i | input | 1 | Channel request line (asynchronous) |
| chan_data_i | input | DATA_W | Channel data bus carrying the I-field |
| chan_connect_o | output | 1 | Connect indication back to the channel |
| host_ifield_o | output | DATA_W | Captured I-field presented to the host |
| host_pending_o | output | 1 | Connection request pending for host decision |
| host_accept_i | input | 1 | Host accepts the pending request |
| host_reject_i | input | 1 | Host rejects the pending request |

## Verification
Most internal faults show up in the latency of one handshake leg. A synchronizer that is one stage short or long moves the rise of the pending flag off the fourth edge. A wrong accept-delay count moves connect off the second edge. A state that misses the loss of the request leaves connect or the flag high past the third edge after removal. A faulty rejected state lets connect rise while accept is held. A capture enable that misfires changes `host_ifield_o` while the bus is moving. Each of these is visible at the ports within a handful of cycles of the stimulus.

// File: rtl/dcc_pkg.sv
// Package: shared types of the destination connection handshake controller.
// Assumes: nothing beyond IEEE 1800-2017.
package dcc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_SYNC_WAIT  = 3'd1,
        ST_NOTIFY     = 3'd2,
        ST_ACC_DELAY  = 3'd3,
        ST_CONNECTED  = 3'd4,
        ST_REJECTED   = 3'd5
    } dcc_state_e;

endpackage

// File: rtl/dcc_sync.sv
// Module: dcc_sync
// Purpose: brings an asynchronous level into the clock domain through a
//          chain of STAGES flops.
// Assumes: STAGES >= 2; the input is a level held for several cycles.
module dcc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    // Stage 0 samples the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= async_i;
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            // Each later stage re-samples the one before it.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[g] <= 1'b0;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/dcc_ifield_reg.sv
// Module: dcc_ifield_reg
// Purpose: holds the header word taken from the channel bus.
// Assumes: the bus is stable while the request is held, and load_i is a
//          one-cycle strobe from the state machine.
module dcc_ifield_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o
);

    logic [DATA_W-1:0] word_q;

    // Capture on the strobe; otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      word_q <= '0;
        else if (load_i) word_q <= data_i;
    end

    assign data_o = word_q;

    AST_IFIELD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(word_q)); // R3

endmodule

// File: rtl/dcc_fsm.sv
// Module: dcc_fsm
// Purpose: sequences the connection handshake. It produces the capture strobe,
//          the host pending flag and the registered channel connect output.
// Assumes: req_i is already synchronized; ACCEPT_LAT >= 2 cycles from the
//          raising of accept to the raising of connect.
module dcc_fsm
    import dcc_pkg::*;
#(
    parameter int ACCEPT_LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic accept_i,
    input  logic reject_i,
    output logic load_o,
    output logic pending_o,
    output logic connect_o
);

    localparam int CNT_W = (ACCEPT_LAT > 2) ? $clog2(ACCEPT_LAT) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACCEPT_LAT - 2);

    dcc_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic              connect_q;

    // Next-state decision; a lost request overrides any host decision.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_i) state_d = ST_SYNC_WAIT;
            ST_SYNC_WAIT: state_d = req_i ? ST_NOTIFY : ST_IDLE;
            ST_NOTIFY: begin
                if (!req_i)        state_d = ST_IDLE;
                else if (reject_i) state_d = ST_REJECTED;
                else if (accept_i) state_d = ST_ACC_DELAY;
            end
            ST_ACC_DELAY: begin
                if (!req_i)                 state_d = ST_IDLE;
                else if (cnt_q == CNT_LAST) state_d = ST_CONNECTED;
            end
            ST_CONNECTED: if (!req_i) state_d = ST_IDLE;
            ST_REJECTED:  if (!req_i) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Accept-delay counter, cleared whenever the delay state is not active.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (state_q == ST_ACC_DELAY) cnt_q <= cnt_q + 1'b1;
        else                             cnt_q <= '0;
    end

    // Connect output register, set only on entry to the connected state.
    always_ff @(posedge clk) begin
        if (!rst_n) connect_q <= 1'b0;
        else        connect_q <= (state_d == ST_CONNECTED);
    end

    assign load_o    = (state_q == ST_IDLE) && req_i;
    assign pending_o = (state_q == ST_NOTIFY);
    assign connect_o = connect_q;

    AST_CONNECT_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(connect_q) |-> $past(state_q) == ST_ACC_DELAY); // R4
    AST_PENDING_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o && !req_i) |=> !pending_o); // R5
    AST_CONNECT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (connect_q && !req_i) |=> !connect_q); // R6
    AST_REJECT_NO_CONNECT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REJECTED) |-> !connect_q); // R7
    AST_REJECT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o && req_i && reject_i) |=> state_q == ST_REJECTED); // R8

endmodule

// File: rtl/dst_conn_ctrl.sv
// Module: dst_conn_ctrl (top)
// Purpose: receiving-side connection handshake. It synchronizes the channel
//          request, captures the I-field, notifies the host, and drives connect
//          a fixed time after the host accepts.
// Assumes: chan_data_i is stable while chan_req_i is held high.
module dst_conn_ctrl #(
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2,
    parameter int ACCEPT_LAT  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_req_i,
    input  logic [DATA_W-1:0] chan_data_i,
    output logic              chan_connect_o,
    output logic [DATA_W-1:0] host_ifield_o,
    output logic              host_pending_o,
    input  logic              host_accept_i,
    input  logic              host_reject_i
);

    logic req_sync;
    logic load_ifield;

    dcc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (chan_req_i),
        .sync_o  (req_sync)
    );

    dcc_ifield_reg #(.DATA_W(DATA_W)) u_ifield (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_ifield),
        .data_i (chan_data_i),
        .data_o (host_ifield_o)
    );

    dcc_fsm #(.ACCEPT_LAT(ACCEPT_LAT)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_sync),
        .accept_i  (host_accept_i),
        .reject_i  (host_reject_i),
        .load_o    (load_ifield),
        .pending_o (host_pending_o),
        .connect_o (chan_connect_o)
    );

    AST_PENDING_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_pending_o) |-> req_sync); // R2
    AST_NO_CONNECT_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_pending_o && chan_connect_o)); // R4

endmodule

// File: tb/dst_conn_ctrl_tb.sv
`timescale 1ns/1ps
module dst_conn_ctrl_tb;

    localparam int DATA_W = 32;
    localparam int NVEC   = 5;
    // Vector: [37:6] I-field, [5:2] idle cycles before decision, [1:0] mode
    // mode 0 accept, 1 reject, 2 withdraw request, 3 accept+reject together
    localparam logic [37:0] VEC [NVEC] = '{
        {32'hA5A5_0001, 4'd0, 2'd0},
        {32'h1234_5678, 4'd3, 2'd0},
        {32'hDEAD_BEEF, 4'd1, 2'd1},
        {32'h0F0F_F0F0, 4'd2, 2'd2},
        {32'hCAFE_0042, 4'd0, 2'd3}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              chan_req = 1'b0;
    logic [DATA_W-1:0] chan_data = '0;
    logic              connect;
    logic [DATA_W-1:0] ifield;
    logic              pending;
    logic              accept = 1'b0;
    logic              reject = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dst_conn_ctrl #(.DATA_W(DATA_W)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .chan_req_i     (chan_req),
        .chan_data_i    (chan_data),
        .chan_connect_o (connect),
        .host_ifield_o  (ifield),
        .host_pending_o (pending),
        .host_accept_i  (accept),
        .host_reject_i  (reject)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One rising edge, then settle away from it.
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    // Raise request and check the four-edge notification leg.
    task automatic open_req(input logic [DATA_W-1:0] w);
        chan_req  = 1'b1;
        chan_data = w;
        step(3);
        chk(pending == 1'b0, "R2 pending early", pending, 0);
        step(1);
        chk(pending == 1'b1, "R2 pending at edge 4", pending, 1);
        chk(ifield == w, "R3 ifield capture", ifield, w);
        chan_data = ~w;
    endtask

    task automatic close_req();
        chan_req = 1'b0;
        step(5);
    endtask

    initial begin
        step(2);
        chk(connect == 1'b0 && pending == 1'b0, "R1 outputs in reset",
            {connect, pending}, 0);
        chk(ifield == '0, "R1 ifield in reset", ifield, 0);
        rst_n = 1'b1;
        step(1);
        chk(connect == 1'b0 && pending == 1'b0 && ifield == '0,
            "R1 after reset", {connect, pending}, 0);

        // Table-driven handshakes.
        for (int v = 0; v < NVEC; v++) begin
            logic [DATA_W-1:0] w;
            int hold;
            int mode;
            w    = VEC[v][37:6];
            hold = int'(VEC[v][5:2]);
            mode = int'(VEC[v][1:0]);
            open_req(w);
            step(hold);
            chk(pending == 1'b1 && ifield == w, "R3 held while waiting", ifield, w);
            case (mode)
                0: begin
                    accept = 1'b1;
                    step(1);
                    accept = 1'b0;
                    chk(pending == 1'b0 && connect == 1'b0, "R4 first edge",
                        {pending, connect}, 0);
                    step(1);
                    chk(connect == 1'b1, "R4 connect at edge 2", connect, 1);
                    chk(ifield == w, "R3 held while connected", ifield, w);
                    chan_req = 1'b0;
                    step(2);
                    chk(connect == 1'b1, "R6 connect before edge 3", connect, 1);
                    step(1);
                    chk(connect == 1'b0, "R6 connect drop at edge 3", connect, 0);
                    step(3);
                end
                1, 3: begin
                    reject = 1'b1;
                    accept = (mode == 3);
                    step(1);
                    reject = 1'b0;
                    chk(pending == 1'b0, mode == 3 ? "R8 pending cleared" :
                        "R7 pending cleared", pending, 0);
                    accept = 1'b1;
                    step(4);
                    chk(connect == 1'b0, mode == 3 ? "R8 reject wins" :
                        "R7 no connect after reject", connect, 0);
                    accept = 1'b0;
                    close_req();
                    chk(connect == 1'b0 && pending == 1'b0, "R7 after removal",
                        {connect, pending}, 0);
                end
                default: begin
                    chan_req = 1'b0;
                    step(2);
                    chk(pending == 1'b1, "R5 pending before edge 3", pending, 1);
                    step(1);
                    chk(pending == 1'b0 && connect == 1'b0, "R5 withdrawn",
                        {pending, connect}, 0);
                    accept = 1'b1;
                    step(3);
                    accept = 1'b0;
                    chk(connect == 1'b0, "R5 late accept ignored", connect, 0);
                    step(2);
                end
            endcase
        end

        // Directed: decisions while idle are ignored.
        reject = 1'b1;
        step(2);
        reject = 1'b0;
        accept = 1'b1;
        step(4);
        accept = 1'b0;
        chk(connect == 1'b0 && pending == 1'b0, "R9 idle decisions ignored",
            {connect, pending}, 0);
        chk(ifield == VEC[NVEC-1][37:6], "R9 ifield untouched", ifield,
            VEC[NVEC-1][37:6]);

        // Directed: a new request after a reject is handled normally.
        open_req(32'h7777_0003);
        accept = 1'b1;
        step(2);
        accept = 1'b0;
        chk(connect == 1'b1, "R7 new request after reject connects", connect, 1);
        close_req();

        // Directed: reset while connected clears everything.
        open_req(32'h0BAD_F00D);
        accept = 1'b1;
        step(2);
        accept = 1'b0;
        rst_n = 1'b0;
        step(1);
        chk(connect == 1'b0 && ifield == '0, "R1 reset mid-connection",
            {connect, ifield}, 0);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #(5ns * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule